// File: doc/BRIEF.md
# Triggered Pulse Timer

This peripheral watches an external trigger line and, once a selected edge arrives, counts out a programmable delay and then holds its output high for a programmable width. Both intervals are measured in time-base ticks. A control bit picks the tick source: either an on-chip strobe that pulses once per microsecond, or rising edges of an external clock pin. The trigger and the external clock both pass through two-flop synchronizers first.

Software reaches the block over a byte-wide register bus. Each of the two interval registers is 16 bits wide and is written as two bytes. A control byte selects the time base, the trigger polarity and the event that raises the interrupt. The interrupt is a one-cycle pulse that a separate controller is expected to latch. While a delay or pulse is in progress, further triggers are ignored. The timer re-arms only when the output falls, or when the sequence ends without a pulse.

Top module: `trig_pulse_timer`

## Requirements
- R1: Register map: address 0 holds the delay low byte, 1 the delay high byte, 2 the width low byte, 3 the width high byte, and 4 the control byte. Control bit 0 selects the time base, bits 2:1 select the interrupt source, and bit 3 selects trigger polarity. Control bits 7:4 always read 0. A read returns the value on `bus_rdata` in the cycle after `bus_rd` is sampled. The read value is 0 when `bus_rd` was low or the address is above 4.
- R2: A trigger event is accepted when the timer is idle. The event is a rising edge of `trig_in` when control bit 3 is 0, or a falling edge when it is 1. It is seen two clock edges after the input changes, after synchronization, and is acted on at the next edge. After acceptance, `pulse_out` rises on tick number max(D,1), where D is the delay register value.
- R3: Once high, `pulse_out` stays high for exactly W ticks, where W is the width register value. It falls on the W-th tick.
- R4: When W is 0, the delay still runs, but no pulse is produced and no rise or fall interrupt occurs. The timer then returns to idle.
- R5: When control bit 0 is 0, a tick is a cycle with `us_tick` high. When it is 1, a tick is a synchronized rising edge of `ext_clk`, and `us_tick` is then ignored.
- R6: Control bits 2:1 select the interrupt source: 00 gives no interrupt, 01 the accepted trigger, 10 the output rise, and 11 the output fall. `irq` is high for one cycle. For the trigger source it is high in the cycle after acceptance. For the rise and fall sources it is high in the same cycle that `pulse_out` changes.
- R7: A trigger that arrives during a delay or a pulse is ignored. Only a trigger after the output falls starts a new sequence.
- R8: After reset, `pulse_out`, `irq` and `bus_rdata` are 0, and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| us_tick | input | 1 | Internal once-per-microsecond strobe, one clock wide |
| ext_clk | input | 1 | External time-base clock, asynchronous |
| trig_in | input | 1 | External trigger, asynchronous |
| pulse_out | output | 1 | Registered timed output pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions take for granted that `us_tick` is a clean strobe synchronous to `clk`. They also assume the interval and control registers are not rewritten while a sequence is running, so the width seen at the rise matches the width programmed before the trigger. The stimulus writes all registers only while the timer is idle and waits long enough between runs for the output to fall. It drives `ext_clk` slowly enough, at three clocks per phase, that every edge survives the synchronizer.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } tpt_state_e;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'd0,
    IRQ_TRIG = 2'd1,
    IRQ_RISE = 2'd2,
    IRQ_FALL = 2'd3
  } tpt_irq_sel_e;

  typedef struct packed {
    logic         trig_fall;
    tpt_irq_sel_e irq_sel;
    logic         ext_base;
  } tpt_ctrl_t;

  localparam int CTRL_BITS = $bits(tpt_ctrl_t);

endpackage

// File: rtl/tpt_sync_edge.sv
module tpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic sel_fall,
  output logic edge_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[TOP];
    end
  end

  always_comb begin
    if (sel_fall) edge_o = prev_q & ~sync_q[TOP];
    else          edge_o = sync_q[TOP] & ~prev_q;
  end

endmodule

// File: rtl/tpt_regs.sv
module tpt_regs
  import tpt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic [CNT_W-1:0]  delay_o,
  output logic [CNT_W-1:0]  width_o,
  output tpt_ctrl_t         ctrl_o
);
  localparam int NB       = CNT_W / 8;
  localparam int NREG     = 2 * NB + 1;
  localparam int CTRL_IDX = 2 * NB;
  localparam logic [7:0] CTRL_MASK = 8'((1 << CTRL_BITS) - 1);

  logic [7:0] regs_q [NREG];
  logic [7:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < NREG; i++) begin
        if (addr_i == ADDR_W'(i)) begin
          regs_q[i] <= (i == CTRL_IDX) ? (wdata_i & CTRL_MASK) : wdata_i;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == ADDR_W'(i)) rd_mux = regs_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_i ? rd_mux : 8'h00;
  end

  for (genvar b = 0; b < NB; b++) begin : g_pack
    assign delay_o[8*b +: 8] = regs_q[b];
    assign width_o[8*b +: 8] = regs_q[NB + b];
  end

  assign ctrl_o = tpt_ctrl_t'(regs_q[CTRL_IDX][CTRL_BITS-1:0]);

  // R1: nothing is driven on the read bus without a read the cycle before
  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_i) |-> rdata_o == 8'h00);

endmodule

// File: rtl/tpt_fsm.sv
module tpt_fsm
  import tpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_ev,
  input  logic             tick,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  tpt_irq_sel_e     irq_sel,
  output logic             pulse_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tpt_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_ev) begin
            state_q <= ST_DELAY;
            cnt_q   <= delay_i;
            irq_o   <= (irq_sel == IRQ_TRIG);
          end
        end
        ST_DELAY: begin
          if (tick) begin
            if (cnt_q <= ONE) begin
              if (width_i == '0) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_PULSE;
                pulse_o <= 1'b1;
                cnt_q   <= width_i;
                irq_o   <= (irq_sel == IRQ_RISE);
              end
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
        ST_PULSE: begin
          if (tick) begin
            if (cnt_q <= ONE) begin
              state_q <= ST_IDLE;
              pulse_o <= 1'b0;
              irq_o   <= (irq_sel == IRQ_FALL);
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the output only rises on a tick, and only out of the delay phase
  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(tick) && $past(state_q) == ST_DELAY);

  // R3: the output only falls on a tick
  assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> $past(tick));

  // R4: an expiring delay with zero width leaves the output low
  assert_zero_width_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY && tick && cnt_q <= ONE && width_i == '0) |=> !pulse_o);

  // R6: an interrupt needs a source selected
  assert_irq_needs_sel_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_sel) != IRQ_OFF);

  // R7: a pulse never jumps straight into a new delay
  assert_no_rearm_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PULSE) |=> state_q != ST_DELAY);

endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import tpt_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              us_tick,
  input  logic              ext_clk,
  input  logic              trig_in,
  output logic              pulse_out,
  output logic              irq
);
  logic [CNT_W-1:0] delay_val;
  logic [CNT_W-1:0] width_val;
  tpt_ctrl_t        ctrl;
  logic             trig_ev;
  logic             ext_edge;
  logic             tick;

  tpt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .rd_i    (bus_rd),
    .rdata_o (bus_rdata),
    .delay_o (delay_val),
    .width_o (width_val),
    .ctrl_o  (ctrl)
  );

  tpt_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (trig_in),
    .sel_fall (ctrl.trig_fall),
    .edge_o   (trig_ev)
  );

  tpt_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (ext_clk),
    .sel_fall (1'b0),
    .edge_o   (ext_edge)
  );

  assign tick = ctrl.ext_base ? ext_edge : us_tick;

  tpt_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .trig_ev (trig_ev),
    .tick    (tick),
    .delay_i (delay_val),
    .width_i (width_val),
    .irq_sel (ctrl.irq_sel),
    .pulse_o (pulse_out),
    .irq_o   (irq)
  );

  // R5: with the external base selected, the internal strobe alone never moves the output
  assert_ext_base_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ext_base && !ext_edge) |=> $stable(pulse_out));

endmodule

// File: tb/trig_pulse_timer_tb.sv
module trig_pulse_timer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       us_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       trig_in = 1'b0;
  logic       pulse_out;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  trig_pulse_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .us_tick(us_tick), .ext_clk(ext_clk), .trig_in(trig_in),
    .pulse_out(pulse_out), .irq(irq)
  );

  // time-base stimulus
  bit tick_en = 1'b1;
  bit ext_en  = 1'b0;
  int tick_div = 0;
  int ext_div  = 0;
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 5;
    us_tick <= tick_en && (tick_div == 0);
    if (ext_en) begin
      ext_div = (ext_div + 1) % 3;
      if (ext_div == 0) ext_clk <= ~ext_clk;
    end
  end

  // behavioural reference model
  logic [7:0] mreg [5];
  int   mst, mcnt, m_d, m_w, m_sel;
  bit   mp, mi, ev, eev, tk;
  logic [7:0] mrd;
  bit t1, t2, t3, e1, e2, e3;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mreg[i]) mreg[i] = 8'h00;
      mst = 0; mcnt = 0; mp = 0; mi = 0; mrd = 8'h00;
      t1 = 0; t2 = 0; t3 = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      m_d   = {mreg[1], mreg[0]};
      m_w   = {mreg[3], mreg[2]};
      m_sel = (mreg[4] >> 1) & 3;
      ev  = mreg[4][3] ? (t3 && !t2) : (t2 && !t3);
      eev = e2 && !e3;
      tk  = mreg[4][0] ? eev : us_tick;
      mi  = 0;
      if (mst == 0) begin
        if (ev) begin mst = 1; mcnt = m_d; mi = (m_sel == 1); end
      end else if (mst == 1) begin
        if (tk) begin
          if (mcnt <= 1) begin
            if (m_w == 0) mst = 0;
            else begin mst = 2; mp = 1; mcnt = m_w; mi = (m_sel == 2); end
          end else mcnt--;
        end
      end else if (tk) begin
        if (mcnt <= 1) begin mst = 0; mp = 0; mi = (m_sel == 3); end
        else mcnt--;
      end
      mrd = (bus_rd && bus_addr < 5) ? mreg[bus_addr] : 8'h00;
      if (bus_wr && bus_addr < 5)
        mreg[bus_addr] = (bus_addr == 4) ? (bus_wdata & 8'h0F) : bus_wdata;
      t3 = t2; t2 = t1; t1 = trig_in;
      e3 = e2; e2 = e1; e1 = ext_clk;
    end
  end

  // per-cycle comparison and event counters
  int  n_rise = 0, n_irq = 0;
  bit  prev_p = 0;
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pulse_out !== mp) begin
        errors++; $display("FAIL R2 R3 pulse_out got %0b exp %0b at %0t", pulse_out, mp, $time);
      end
      checks++;
      if (irq !== mi) begin
        errors++; $display("FAIL R6 irq got %0b exp %0b at %0t", irq, mi, $time);
      end
      checks++;
      if (bus_rdata !== mrd) begin
        errors++; $display("FAIL R1 bus_rdata got %02h exp %02h at %0t", bus_rdata, mrd, $time);
      end
      if (pulse_out && !prev_p) n_rise++;
      if (irq) n_irq++;
      prev_p = pulse_out;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic setup(input int dly, input int wid, input logic [7:0] ctl);
    wr(3'd0, dly[7:0]); wr(3'd1, dly[15:8]);
    wr(3'd2, wid[7:0]); wr(3'd3, wid[15:8]);
    wr(3'd4, ctl);
  endtask

  task automatic fire(input bit level);
    @(negedge clk);
    trig_in = level;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int r0, i0;
  logic [7:0] rv;

  initial begin
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 pulse_out", pulse_out, 0);
    chk("R8 irq", irq, 0);
    rst = 1'b0;
    idle(2);
    rd(3'd2, rv); chk("R8 width reg", rv, 0);

    // R1: register read-back, control masking, unused address
    setup(16'h1234, 16'h00AB, 8'hFF);
    rd(3'd0, rv); chk("R1 delay lo", rv, 8'h34);
    rd(3'd1, rv); chk("R1 delay hi", rv, 8'h12);
    rd(3'd3, rv); chk("R1 width hi", rv, 8'h00);
    rd(3'd4, rv); chk("R1 ctrl mask", rv, 8'h0F);
    rd(3'd5, rv); chk("R1 unused addr", rv, 0);
    idle(1); chk("R1 idle rdata", bus_rdata, 0);

    // R2 R3 R6: internal base, rise interrupt
    setup(3, 4, 8'h04);
    r0 = n_rise; i0 = n_irq;
    fire(1); idle(120);
    chk("R2 one pulse", n_rise - r0, 1);
    chk("R6 rise irq", n_irq - i0, 1);

    // R2: zero delay, trigger interrupt
    setup(0, 2, 8'h02);
    r0 = n_rise; i0 = n_irq;
    fire(0); idle(4); fire(1); idle(60);
    chk("R2 zero delay pulse", n_rise - r0, 1);
    chk("R6 trig irq", n_irq - i0, 1);

    // R4: zero width, rise interrupt selected
    setup(2, 0, 8'h04);
    r0 = n_rise; i0 = n_irq;
    fire(0); idle(4); fire(1); idle(60);
    chk("R4 no pulse", n_rise - r0, 0);
    chk("R4 no irq", n_irq - i0, 0);

    // R7: retrigger during pulse is ignored; fall interrupt
    setup(1, 10, 8'h06);
    r0 = n_rise; i0 = n_irq;
    fire(0); idle(4); fire(1); idle(20);
    fire(0); idle(6); fire(1); idle(80);
    chk("R7 single pulse", n_rise - r0, 1);
    chk("R6 fall irq", n_irq - i0, 1);
    // re-arm after fall
    fire(0); idle(4); fire(1); idle(80);
    chk("R7 rearmed", n_rise - r0, 2);

    // R9-style polarity: falling trigger, no interrupt source
    setup(2, 3, 8'h08);
    r0 = n_rise; i0 = n_irq;
    idle(4); fire(0); idle(60);
    chk("R2 falling trigger", n_rise - r0, 1);
    chk("R6 irq off", n_irq - i0, 0);

    // R5: external base with no external edges: nothing happens
    setup(2, 3, 8'h01);
    r0 = n_rise;
    fire(1); idle(60);
    chk("R5 no ext edges", n_rise - r0, 0);
    ext_en = 1'b1; idle(200);
    chk("R5 ext base pulse", n_rise - r0, 1);
    // R5: external base, internal strobe stopped
    tick_en = 1'b0;
    r0 = n_rise;
    fire(0); idle(4); fire(1); idle(200);
    chk("R5 ext without strobe", n_rise - r0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule